// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is the host-side master for an 8-bit successive-approximation converter with a three-wire serial read path. It divides the system clock to make the serial clock, drives the active-low chip select and shifts the returned bit stream into a parallel sample. Each good sample appears on `sample_o` with a one-cycle `valid_o` strobe. A pulse on `start_i` runs one conversion frame. `busy_o` stays high until the frame and its following quiet gap are over. Start pulses that arrive while `busy_o` is high are dropped.

Asserting `sleep_req_i` together with `start_i` runs a short frame. Chip select is released after a fixed count of falling serial-clock edges, which powers the converter down. The first start after that runs a wake sequence of two frames. The first is a full-length frame whose result is thrown away. The second is a normal frame whose result is delivered. The serial clock rate, the frame length, the release point of the short frame and the quiet gap are all parameters. Elaboration checks confirm that the acquisition time after the track point is met.

Top module: `sar_serial_reader`

## Requirements
- R1: While `rst_n` is low and just after its release, `cs_n_o` and `sclk_o` are high, `busy_o` and `valid_o` are low and `sample_o` is zero.
- R2: A normal frame holds `cs_n_o` low across exactly FRAME_CYC falling edges of `sclk_o`. `cs_n_o` falls only while `sclk_o` is high, and the first falling edge comes half a serial period later.
- R3: The controller samples `sdata_i` on each falling edge of `sclk_o`. The bits present before falling edges 4 to 11 form the sample, MSB first, after three leading zeros. The sample is published on `sample_o` with `valid_o` high for exactly one clock after the frame ends.
- R4: Inside a frame, `sclk_o` has a period of 2*CLK_DIV system clocks with equal high and low halves. It stays high outside frames.
- R5: At least 350 ns pass from the 13th rising edge of `sclk_o` in a frame to the next fall of `cs_n_o`. Parameters that cannot meet this fail elaboration.
- R6: `busy_o` is high from the clock after an accepted start until the quiet gap after the last frame has ended. A start seen while busy is ignored and produces no extra frame.
- R7: A start with `sleep_req_i` high, while the converter is awake, gives a frame of SLEEP_EDGES falling edges (2 to 9). `cs_n_o` rises before the next falling edge, and no `valid_o` follows.
- R8: The first start after a sleep frame runs two frames. The first lasts FRAME_CYC edges and its data is discarded. The second delivers one sample through `valid_o`.
- R9: A sleep request while the converter is already asleep starts no frame and leaves `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion (or a sleep frame) |
| sleep_req_i | input | 1 | With `start_i`: power the converter down |
| sdata_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| cs_n_o | output | 1 | Active-low chip select |
| busy_o | output | 1 | Frame or quiet gap in progress |
| sample_o | output | WORD_W | Last delivered sample |
| valid_o | output | 1 | One-cycle strobe for a new sample |

## Verification
A table of words drives a converter model. The words are all zeros, all ones, bits set only at both ends of the word, and an uneven pattern. Together they show whether any bit is lost, shifted by one edge or reversed. The sleep frames are mixed in among them, so that counts of chip-select frames and strobes tell a normal frame from a sleep frame and from a wake pair. While asleep, the model returns the inverted word, so a dummy result that leaks out shows up as a wrong sample. A second sleep request while asleep and a start pulse during a busy frame show whether ignored requests are really ignored. Serial-clock timing, the chip-select phase and the acquisition gap are measured on every frame.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_FRAME = 2'd1,
      SEQ_GAP   = 2'd2
   } seq_state_e;

   typedef enum logic [1:0] {
      FR_NORMAL = 2'd0,
      FR_SLEEP  = 2'd1,
      FR_WAKE   = 2'd2
   } frame_kind_e;
endpackage

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen #(
   parameter int CLK_DIV = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic halt_i,
   output logic sclk_o,
   output logic fall_o
);
   logic sclk_q;
   logic tick;

   if (CLK_DIV < 1) begin : g_bad_div
      $error("CLK_DIV must be at least 1");
   end

   if (CLK_DIV == 1) begin : g_div1
      assign tick = run_i;
   end else begin : g_divn
      localparam int HW = $clog2(CLK_DIV);
      logic [HW-1:0] hcnt;
      assign tick = run_i && (hcnt == HW'(CLK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hcnt <= '0;
         end else if (!run_i || halt_i || tick) begin
            hcnt <= '0;
         end else begin
            hcnt <= hcnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b1;
      end else if (!run_i || halt_i) begin
         sclk_q <= 1'b1;
      end else if (tick) begin
         sclk_q <= ~sclk_q;
      end
   end

   assign fall_o = tick && sclk_q;
   assign sclk_o = sclk_q;

   // R4
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> sclk_o);
endmodule

// File: rtl/sar_frame_seq.sv
module sar_frame_seq
   import sar_rd_pkg::*;
#(
   parameter int FRAME_CYC   = 20,
   parameter int SLEEP_EDGES = 4,
   parameter int GAP_CYC     = 2,
   localparam int CW = $clog2(FRAME_CYC + 1),
   localparam int GW = $clog2(GAP_CYC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          sleep_req_i,
   input  logic          fall_i,
   output logic          cs_n_o,
   output logic          halt_o,
   output logic          publish_o,
   output logic          busy_o,
   output logic [CW-1:0] edge_cnt_o
);
   seq_state_e    state;
   frame_kind_e   kind;
   logic          cs_n_q;
   logic          asleep;
   logic [CW-1:0] fcnt;
   logic [GW-1:0] gcnt;
   logic [CW-1:0] limit;
   logic          halt;
   logic          accept;

   assign limit  = (kind == FR_SLEEP) ? CW'(SLEEP_EDGES) : CW'(FRAME_CYC);
   assign halt   = (state == SEQ_FRAME) && fall_i && (fcnt == limit);
   assign accept = start_i && !(sleep_req_i && asleep);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SEQ_IDLE;
         kind   <= FR_NORMAL;
         cs_n_q <= 1'b1;
         asleep <= 1'b0;
         fcnt   <= '0;
         gcnt   <= '0;
      end else begin
         case (state)
            SEQ_IDLE: begin
               if (accept) begin
                  state  <= SEQ_FRAME;
                  cs_n_q <= 1'b0;
                  fcnt   <= '0;
                  if (sleep_req_i)  kind <= FR_SLEEP;
                  else if (asleep)  kind <= FR_WAKE;
                  else              kind <= FR_NORMAL;
               end
            end
            SEQ_FRAME: begin
               if (halt) begin
                  cs_n_q <= 1'b1;
                  state  <= SEQ_GAP;
                  gcnt   <= '0;
                  if (kind == FR_SLEEP) asleep <= 1'b1;
                  if (kind == FR_WAKE)  asleep <= 1'b0;
               end else if (fall_i) begin
                  fcnt <= fcnt + 1'b1;
               end
            end
            SEQ_GAP: begin
               if (gcnt == GW'(GAP_CYC - 1)) begin
                  if (kind == FR_WAKE) begin
                     kind   <= FR_NORMAL;
                     state  <= SEQ_FRAME;
                     cs_n_q <= 1'b0;
                     fcnt   <= '0;
                  end else begin
                     state <= SEQ_IDLE;
                  end
               end else begin
                  gcnt <= gcnt + 1'b1;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign cs_n_o     = cs_n_q;
   assign halt_o     = halt;
   assign publish_o  = halt && (kind == FR_NORMAL);
   assign busy_o     = (state != SEQ_IDLE);
   assign edge_cnt_o = fcnt;

   // R2
   edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_i |-> (fcnt <= CW'(FRAME_CYC)));
   // R7
   sleep_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_FRAME && kind == FR_SLEEP && fall_i) |-> (fcnt <= CW'(SLEEP_EDGES)));
   // R9
   sleep_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_IDLE && asleep && start_i && sleep_req_i) |=> !busy_o);
endmodule

// File: rtl/sar_shift_capture.sv
module sar_shift_capture #(
   parameter int WORD_W     = 8,
   parameter int LEAD_ZEROS = 3,
   parameter int CW         = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall_i,
   input  logic [CW-1:0]     edge_cnt_i,
   input  logic              sdata_i,
   input  logic              publish_i,
   output logic [WORD_W-1:0] sample_o,
   output logic              valid_o
);
   localparam int FIRST = LEAD_ZEROS;
   localparam int LAST  = LEAD_ZEROS + WORD_W - 1;

   logic [WORD_W-1:0] sreg;
   logic              in_window;

   assign in_window = (edge_cnt_i >= CW'(FIRST)) && (edge_cnt_i <= CW'(LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
      end else if (fall_i && in_window) begin
         sreg <= {sreg[WORD_W-2:0], sdata_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_o <= '0;
         valid_o  <= 1'b0;
      end else begin
         valid_o <= publish_i;
         if (publish_i) sample_o <= sreg;
      end
   end

   // R3
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
   // R3
   sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> $stable(sample_o));
endmodule

// File: rtl/sar_serial_reader.sv
module sar_serial_reader #(
   parameter int CLK_DIV     = 5,
   parameter int FRAME_CYC   = 20,
   parameter int SLEEP_EDGES = 4,
   parameter int GAP_CYC     = 2,
   parameter int WORD_W      = 8,
   parameter int LEAD_ZEROS  = 3,
   parameter int SYS_PS      = 5000,
   parameter int ACQ_PS      = 350000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              sleep_req_i,
   input  logic              sdata_i,
   output logic              sclk_o,
   output logic              cs_n_o,
   output logic              busy_o,
   output logic [WORD_W-1:0] sample_o,
   output logic              valid_o
);
   localparam int  CW       = $clog2(FRAME_CYC + 1);
   localparam int  TRACK_HALVES = 2 * (FRAME_CYC - 13) + 1;
   localparam longint GAP_PS = longint'(TRACK_HALVES * CLK_DIV + GAP_CYC) * longint'(SYS_PS);

   if (FRAME_CYC < 16) begin : g_bad_frame
      $error("FRAME_CYC must be at least 16");
   end
   if (SLEEP_EDGES < 2 || SLEEP_EDGES > 9) begin : g_bad_sleep
      $error("SLEEP_EDGES must lie between 2 and 9");
   end
   if (GAP_CYC < 1) begin : g_bad_gap
      $error("GAP_CYC must be at least 1");
   end
   if (LEAD_ZEROS + WORD_W > FRAME_CYC) begin : g_bad_word
      $error("word does not fit in the frame");
   end
   // R5
   if (GAP_PS < longint'(ACQ_PS)) begin : g_bad_acq
      $error("acquisition gap after the track point is too short");
   end

   logic          fall;
   logic          halt;
   logic          publish;
   logic [CW-1:0] edge_cnt;
   logic          cs_n;

   sar_frame_seq #(
      .FRAME_CYC  (FRAME_CYC),
      .SLEEP_EDGES(SLEEP_EDGES),
      .GAP_CYC    (GAP_CYC)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .sleep_req_i(sleep_req_i),
      .fall_i     (fall),
      .cs_n_o     (cs_n),
      .halt_o     (halt),
      .publish_o  (publish),
      .busy_o     (busy_o),
      .edge_cnt_o (edge_cnt)
   );

   sar_sclk_gen #(
      .CLK_DIV(CLK_DIV)
   ) u_sclk (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (!cs_n),
      .halt_i(halt),
      .sclk_o(sclk_o),
      .fall_o(fall)
   );

   sar_shift_capture #(
      .WORD_W    (WORD_W),
      .LEAD_ZEROS(LEAD_ZEROS),
      .CW        (CW)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .fall_i    (fall),
      .edge_cnt_i(edge_cnt),
      .sdata_i   (sdata_i),
      .publish_i (publish),
      .sample_o  (sample_o),
      .valid_o   (valid_o)
   );

   assign cs_n_o = cs_n;

   // R2
   cs_fall_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> sclk_o);
   // R6
   cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_o && !halt) |=> busy_o);
endmodule

// File: tb/sar_serial_reader_test.sv
`timescale 1ns/1ps
module sar_serial_reader_test;
   localparam int  CLK_DIV     = 5;
   localparam int  FRAME_CYC   = 20;
   localparam int  SLEEP_EDGES = 4;
   localparam real SCLK_NS     = 2.0 * CLK_DIV * 5.0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       sleep_req = 1'b0;
   logic       sdata = 1'b0;
   logic       sclk, cs_n, busy, valid;
   logic [7:0] sample;

   int n_chk = 0, n_bad = 0, cyc = 0;

   always #2.5 clk = ~clk;

   sar_serial_reader uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .sleep_req_i(sleep_req),
      .sdata_i(sdata), .sclk_o(sclk), .cs_n_o(cs_n), .busy_o(busy),
      .sample_o(sample), .valid_o(valid)
   );

   // converter model
   bit         asleep_m = 1'b0;
   bit         have13 = 1'b0;
   int         falls_m = 0, rises_m = 0, frames = 0, last_falls = 0;
   int         gap_bad = 0, csfall_bad = 0, per_bad = 0;
   logic [7:0] adc_word = 8'h00, fw = 8'h00;
   realtime    t13 = 0.0, t_fall = 0.0;
   int         vcount = 0;
   logic [7:0] vsample = 8'h00;

   function automatic logic bitv(input int b, input logic [7:0] w);
      return (b >= 3 && b <= 10) ? w[10-b] : 1'b0;
   endfunction

   function automatic real absr(input real x);
      return (x < 0.0) ? -x : x;
   endfunction

   always @(negedge cs_n) begin
      if (have13 && ($realtime - t13) < 350.0) gap_bad++;
      if (sclk !== 1'b1) csfall_bad++;
      falls_m = 0;
      rises_m = 0;
      have13  = 1'b0;
      fw      = asleep_m ? ~adc_word : adc_word;
      sdata  <= #1 bitv(0, fw);
   end

   always @(negedge sclk) begin
      if (cs_n === 1'b0) begin
         falls_m++;
         if (falls_m > 1 && absr($realtime - t_fall - SCLK_NS) > 0.01) per_bad++;
         t_fall = $realtime;
         sdata <= #1 bitv(falls_m, fw);
      end
   end

   always @(posedge sclk) begin
      if (cs_n === 1'b0) begin
         rises_m++;
         if (absr($realtime - t_fall - SCLK_NS / 2.0) > 0.01) per_bad++;
         if (rises_m == 13) begin
            t13    = $realtime;
            have13 = 1'b1;
         end
      end
   end

   always @(posedge cs_n) begin
      if (rst_n) begin
         if (falls_m >= 10) asleep_m = 1'b0;
         else if (falls_m >= 2) asleep_m = 1'b1;
         frames++;
         last_falls = falls_m;
      end
   end

   always @(negedge clk) begin
      if (rst_n && valid === 1'b1) begin
         vcount++;
         vsample = sample;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   typedef struct packed {
      logic       slp;
      logic [7:0] word;
      int         exp_frames;
      int         exp_valid;
   } vec_t;

   localparam vec_t VEC [10] = '{
      '{1'b0, 8'h00, 1, 1},
      '{1'b0, 8'hFF, 1, 1},
      '{1'b0, 8'h81, 1, 1},
      '{1'b0, 8'h6E, 1, 1},
      '{1'b1, 8'h33, 1, 0},
      '{1'b1, 8'h44, 0, 0},
      '{1'b0, 8'h3C, 2, 1},
      '{1'b0, 8'h5A, 1, 1},
      '{1'b1, 8'h12, 1, 0},
      '{1'b0, 8'hC3, 2, 1}
   };

   task automatic wait_idle();
      int w = 0;
      while (busy && w < 5000) begin
         @(negedge clk);
         w++;
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(cs_n === 1'b1, "R1 cs_n", int'(cs_n), 1);
      chk(sclk === 1'b1, "R1 sclk", int'(sclk), 1);
      chk(busy === 1'b0 && valid === 1'b0, "R1 busy/valid", int'({busy, valid}), 0);
      chk(sample === 8'h00, "R1 sample", int'(sample), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(cs_n === 1'b1 && sclk === 1'b1 && busy === 1'b0, "R1 after release",
          int'({cs_n, sclk, busy}), 6);

      for (int i = 0; i < 10; i++) begin
         int f0;
         adc_word = VEC[i].word;
         f0       = frames;
         vcount   = 0;
         start    = 1'b1;
         sleep_req = VEC[i].slp;
         @(negedge clk);
         start    = 1'b0;
         sleep_req = 1'b0;
         // R6 / R9
         chk(busy === (VEC[i].exp_frames > 0), "R6 R9 busy after start",
             int'(busy), int'(VEC[i].exp_frames > 0));
         wait_idle();
         // R2 R7 R8 R9 frame count
         chk(frames - f0 == VEC[i].exp_frames, "R2 R8 R9 frames", frames - f0,
             VEC[i].exp_frames);
         // R3 R7 R8 strobe count
         chk(vcount == VEC[i].exp_valid, "R3 R7 R8 valid count", vcount, VEC[i].exp_valid);
         if (VEC[i].exp_valid == 1)
            chk(vsample === VEC[i].word, "R3 sample", int'(vsample), int'(VEC[i].word));
         if (VEC[i].exp_frames > 0) begin
            if (VEC[i].slp)
               chk(last_falls == SLEEP_EDGES, "R7 sleep edges", last_falls, SLEEP_EDGES);
            else
               chk(last_falls == FRAME_CYC, "R2 frame edges", last_falls, FRAME_CYC);
         end
      end

      // R6 start during busy is ignored
      begin
         int f0;
         adc_word = 8'h99;
         f0       = frames;
         vcount   = 0;
         start    = 1'b1;
         @(negedge clk);
         start    = 1'b0;
         repeat (20) @(negedge clk);
         start    = 1'b1;
         @(negedge clk);
         start    = 1'b0;
         wait_idle();
         chk(frames - f0 == 1, "R6 ignored start frames", frames - f0, 1);
         chk(vcount == 1 && vsample === 8'h99, "R6 ignored start sample", int'(vsample), 153);
      end

      chk(per_bad == 0, "R4 sclk period/duty errors", per_bad, 0);
      chk(gap_bad == 0, "R5 acquisition gap violations", gap_bad, 0);
      chk(csfall_bad == 0, "R2 cs fell with sclk low", csfall_bad, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule